// File: doc/BRIEF.md
# Banked Array Admission Tracker

This block sits in front of a storage array that is split into several independent banks. Each bank can serve only one access at a time, and an access holds the bank for a fixed number of cycles. In every cycle, each request port may present one index. The tracker works out which bank that index belongs to and answers at once whether the access may start. It also records every access it admits so that later requests to the same bank are refused until the bank frees up. Moving data is outside its scope. It only decides admission and tracks how long each bank stays occupied.

Several ports can ask in the same cycle. They are resolved in fixed priority, with the lowest-numbered port first. Two ports may name the same index in the cycle that one of them claims a bank. Both are then admitted, because they are treated as the same access requested twice rather than as a conflict. When the occupancy parameter is zero, the array behaves as if it had no banking limit: every request passes and nothing is tracked.

Top module: `bank_admission_tracker`

## Requirements
- R1: With more than one bank, the bank reported for a port equals its index modulo NUM_BANKS. NUM_BANKS is a power of two, so this is the low log2(NUM_BANKS) index bits; for example, index 13 maps to bank 1 of 4.
- R2: With NUM_BANKS = 1, every index reports bank 0.
- R3: With LATENCY = 0, each port's grant equals its valid input in every cycle, and no request ever blocks a later one.
- R4: A request admitted as a bank claim in cycle t occupies that bank for exactly LATENCY cycles. Requests to the bank in cycles t+1 to t+LATENCY-1 are denied. A request in cycle t+LATENCY is admitted. A denied request does not extend the occupancy.
- R5: When ports name different indices for the same free bank in one cycle, only the lowest-numbered such port is granted.
- R6: A later port naming the same index and bank as a port that claimed that bank in the same cycle is also granted. It does not move the occupancy window. The claiming port's index is recorded as the bank owner.
- R7: Occupancy of one bank never affects admission to another bank.
- R8: After reset every bank is free, so the first request to any bank is granted.
- R9: A port whose valid input is low is never granted and changes no bank state.
- R10: Grant and reported bank are combinational responses to the inputs of the same cycle. Bank state changes take effect from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | NUM_PORTS | Per-port request valid |
| reqIdx | input | NUM_PORTS*IDX_W | Per-port request index, port p in bits [p*IDX_W +: IDX_W] |
| reqGrant | output | NUM_PORTS | Per-port admission result for this cycle |
| reqBank | output | NUM_PORTS*BANK_W | Per-port selected bank, port p in bits [p*BANK_W +: BANK_W] |

## Verification
The hardest situation to reach from the ports is the same-cycle repeat. It needs one port to claim a free bank while a lower-priority port, in that exact cycle, names the identical index. A nearby index that merely maps to the same bank has to be kept apart from it. The stimulus forces this case directly, and then runs a long pseudo-random stretch over a narrow index range where the second port often copies the first port's index. That makes repeats, clashes and expiring occupancy windows collide often. Three configurations are driven by the same stimulus: four banks with a three-cycle hold, a single bank, and zero latency.

// File: rtl/bat_pkg.sv
package bat_pkg;

  // Widest port selector a strobe can carry (up to 16 request ports).
  localparam int unsigned SRC_W = 4;

  // Per-bank write strobe from control to datapath.
  typedef struct packed {
    logic             claim;    // bank is claimed this cycle
    logic [SRC_W-1:0] srcPort;  // port whose index becomes the owner
  } bankStrobe_t;

endpackage

// File: rtl/bat_datapath.sv
module bat_datapath
  import bat_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned NUM_PORTS = 2,
  parameter int unsigned IDX_W     = 16,
  parameter int unsigned LATENCY   = 3,
  parameter int unsigned CYC_W     = 32,
  localparam int unsigned BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_PORTS*IDX_W-1:0]    reqIdx,
  input  bankStrobe_t [NUM_BANKS-1:0]   strobe,
  output logic [NUM_PORTS*BANK_W-1:0]   portBank,
  output logic [NUM_BANKS-1:0]          bankBusy,
  output logic [NUM_BANKS*IDX_W-1:0]    ownerIdx
);

  // Bank selection: modulo by a power of two keeps the low index bits.
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_map
    if (NUM_BANKS == 1) begin : g_single
      assign portBank[p*BANK_W +: BANK_W] = '0;
    end else begin : g_multi
      assign portBank[p*BANK_W +: BANK_W] = reqIdx[p*IDX_W +: BANK_W];
    end
  end

  if (LATENCY == 0) begin : g_untracked
    assign bankBusy = '0;
    assign ownerIdx = '0;
  end else begin : g_tracked
    logic [CYC_W-1:0] nowCycle;

    always_ff @(posedge clk) begin
      if (!rstN) nowCycle <= '0;
      else       nowCycle <= nowCycle + 1'b1;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic             holdValid;
      logic [CYC_W-1:0] holdStart;
      logic [IDX_W-1:0] holdIdx;
      logic [CYC_W-1:0] elapsed;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          holdValid <= 1'b0;
          holdStart <= '0;
          holdIdx   <= '0;
        end else if (strobe[b].claim) begin
          holdValid <= 1'b1;
          holdStart <= nowCycle;
          holdIdx   <= reqIdx[strobe[b].srcPort*IDX_W +: IDX_W];
        end
      end

      // Age of the current hold; busy while younger than the latency.
      assign elapsed     = nowCycle - holdStart;
      assign bankBusy[b] = holdValid && (elapsed < CYC_W'(LATENCY));
      assign ownerIdx[b*IDX_W +: IDX_W] = holdIdx;
    end
  end

endmodule

// File: rtl/bat_control.sv
module bat_control
  import bat_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned NUM_PORTS = 2,
  parameter int unsigned IDX_W     = 16,
  parameter int unsigned LATENCY   = 3,
  localparam int unsigned BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic [NUM_PORTS-1:0]          reqValid,
  input  logic [NUM_PORTS*IDX_W-1:0]    reqIdx,
  input  logic [NUM_PORTS*BANK_W-1:0]   portBank,
  input  logic [NUM_BANKS-1:0]          bankBusy,
  output logic [NUM_PORTS-1:0]          reqGrant,
  output bankStrobe_t [NUM_BANKS-1:0]   strobe
);

  if (LATENCY == 0) begin : g_free
    assign reqGrant = reqValid;
    assign strobe   = '0;
  end else begin : g_arbitrate
    always_comb begin
      logic [NUM_PORTS-1:0] claimed;
      logic clash;
      logic dup;
      claimed  = '0;
      reqGrant = '0;
      strobe   = '0;
      // Ports resolve in priority order; earlier claims in this cycle
      // either block a later port or, for the same index, admit it again.
      for (int p = 0; p < NUM_PORTS; p++) begin
        clash = 1'b0;
        dup   = 1'b0;
        for (int q = 0; q < p; q++) begin
          if (claimed[q] &&
              portBank[q*BANK_W +: BANK_W] == portBank[p*BANK_W +: BANK_W]) begin
            if (reqIdx[q*IDX_W +: IDX_W] == reqIdx[p*IDX_W +: IDX_W]) dup = 1'b1;
            else clash = 1'b1;
          end
        end
        if (reqValid[p] && !bankBusy[portBank[p*BANK_W +: BANK_W]] && !clash) begin
          reqGrant[p] = 1'b1;
          claimed[p]  = !dup;
        end
      end
      // At most one claim per bank can survive; route it to the bank entry.
      for (int b = 0; b < NUM_BANKS; b++) begin
        for (int p = 0; p < NUM_PORTS; p++) begin
          if (claimed[p] && !strobe[b].claim &&
              portBank[p*BANK_W +: BANK_W] == BANK_W'(b)) begin
            strobe[b].claim   = 1'b1;
            strobe[b].srcPort = SRC_W'(p);
          end
        end
      end
    end
  end

endmodule

// File: rtl/bank_admission_tracker.sv
module bank_admission_tracker
  import bat_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned NUM_PORTS = 2,
  parameter int unsigned IDX_W     = 16,
  parameter int unsigned LATENCY   = 3,
  parameter int unsigned CYC_W     = 32,
  localparam int unsigned BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_PORTS-1:0]        reqValid,
  input  logic [NUM_PORTS*IDX_W-1:0]  reqIdx,
  output logic [NUM_PORTS-1:0]        reqGrant,
  output logic [NUM_PORTS*BANK_W-1:0] reqBank
);

  bankStrobe_t [NUM_BANKS-1:0]   strobe;
  logic [NUM_BANKS-1:0]          bankBusy;
  logic [NUM_BANKS*IDX_W-1:0]    ownerIdx;
  logic [NUM_PORTS*BANK_W-1:0]   portBank;

  bat_datapath #(
    .NUM_BANKS(NUM_BANKS), .NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W),
    .LATENCY(LATENCY), .CYC_W(CYC_W)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .reqIdx(reqIdx), .strobe(strobe),
    .portBank(portBank), .bankBusy(bankBusy), .ownerIdx(ownerIdx)
  );

  bat_control #(
    .NUM_BANKS(NUM_BANKS), .NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W),
    .LATENCY(LATENCY)
  ) u_control (
    .reqValid(reqValid), .reqIdx(reqIdx), .portBank(portBank),
    .bankBusy(bankBusy), .reqGrant(reqGrant), .strobe(strobe)
  );

  assign reqBank = portBank;

endmodule

// File: rtl/bat_checker.sv
module bat_checker #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned NUM_PORTS = 2,
  parameter int unsigned IDX_W     = 16,
  parameter int unsigned LATENCY   = 3,
  localparam int unsigned BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input logic                        clk,
  input logic                        rstN,
  input logic [NUM_PORTS-1:0]        reqValid,
  input logic [NUM_PORTS*IDX_W-1:0]  reqIdx,
  input logic [NUM_PORTS-1:0]        reqGrant,
  input logic [NUM_PORTS*BANK_W-1:0] reqBank,
  input logic [NUM_BANKS*IDX_W-1:0]  ownerIdx
);

  // R9: no grant without a request.
  assert_grant_needs_valid_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqGrant & ~reqValid) == '0);

  if (LATENCY == 0) begin : g_zero
    // R3: zero latency admits everything.
    assert_all_admitted_R3: assert property (@(posedge clk) disable iff (!rstN)
      reqGrant == reqValid);
  end else begin : g_timed
    logic             prevClaim;
    logic [BANK_W-1:0] prevBank;
    logic [IDX_W-1:0]  prevIdx;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        prevClaim <= 1'b0;
        prevBank  <= '0;
        prevIdx   <= '0;
      end else begin
        prevClaim <= reqValid[0] && reqGrant[0];
        prevBank  <= reqBank[0 +: BANK_W];
        prevIdx   <= reqIdx[0 +: IDX_W];
      end
    end

    // R6: a claim by the top-priority port records its index as owner.
    assert_owner_recorded_R6: assert property (@(posedge clk) disable iff (!rstN)
      prevClaim |-> ownerIdx[prevBank*IDX_W +: IDX_W] == prevIdx);

    if (LATENCY >= 2) begin : g_hold
      // R4: the bank stays occupied in the cycle after a claim.
      assert_busy_after_claim_R4: assert property (@(posedge clk) disable iff (!rstN)
        prevClaim |-> !(reqValid[0] && reqGrant[0] && reqBank[0 +: BANK_W] == prevBank));
    end else begin : g_single_cycle
      // R4: a one-cycle hold is free again in the next cycle.
      assert_free_after_claim_R4: assert property (@(posedge clk) disable iff (!rstN)
        (prevClaim && reqValid[0] && reqBank[0 +: BANK_W] == prevBank) |-> reqGrant[0]);
    end

    if (NUM_PORTS >= 2) begin : g_pair
      // R5: two grants to one bank in one cycle must share the index.
      assert_pair_same_index_R5: assert property (@(posedge clk) disable iff (!rstN)
        (reqValid[1:0] == 2'b11 && reqGrant[1:0] == 2'b11 &&
         reqBank[0 +: BANK_W] == reqBank[BANK_W +: BANK_W])
        |-> reqIdx[0 +: IDX_W] == reqIdx[IDX_W +: IDX_W]);
    end
  end

endmodule

bind bank_admission_tracker bat_checker #(
  .NUM_BANKS(NUM_BANKS), .NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W), .LATENCY(LATENCY)
) u_bat_checker (.*);

// File: tb/test_bank_admission_tracker.sv
`timescale 1ns/1ps
module test_bank_admission_tracker;

  localparam int IDX_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0]         vIn = '0;
  logic [2*IDX_W-1:0] idxIn = '0;

  logic [1:0] gA, gB, gC;
  logic [3:0] bA, bC;
  logic [1:0] bB;

  always #10 clk = ~clk;  // 50 MHz

  bank_admission_tracker #(.NUM_BANKS(4), .NUM_PORTS(2), .IDX_W(IDX_W), .LATENCY(3))
    i_bank_admission_tracker (.clk(clk), .rstN(rstN), .reqValid(vIn), .reqIdx(idxIn),
                              .reqGrant(gA), .reqBank(bA));
  bank_admission_tracker #(.NUM_BANKS(1), .NUM_PORTS(2), .IDX_W(IDX_W), .LATENCY(2))
    i_bank_admission_tracker_single (.clk(clk), .rstN(rstN), .reqValid(vIn), .reqIdx(idxIn),
                                     .reqGrant(gB), .reqBank(bB));
  bank_admission_tracker #(.NUM_BANKS(4), .NUM_PORTS(2), .IDX_W(IDX_W), .LATENCY(0))
    i_bank_admission_tracker_nolat (.clk(clk), .rstN(rstN), .reqValid(vIn), .reqIdx(idxIn),
                                    .reqGrant(gC), .reqBank(bC));

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  // Behavioural reference: one busy record per configuration and bank.
  int nbCfg  [3] = '{4, 1, 4};
  int latCfg [3] = '{3, 2, 0};
  bit mUsed  [3][4];
  int mStart [3][4];
  int mEnd   [3][4];
  int mIdx   [3][4];
  int cyc = 0;

  task automatic model_reset();
    for (int k = 0; k < 3; k++)
      for (int b = 0; b < 4; b++) begin
        mUsed[k][b] = 1'b0; mStart[k][b] = 0; mEnd[k][b] = 0; mIdx[k][b] = 0;
      end
  endtask

  task automatic check(string tag, int act, int exp, string what);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s cyc=%0d %s actual=%0d expected=%0d", tag, cyc, what, act, exp);
    end
  endtask

  // Compare all three instances for the current inputs, then advance the model.
  task automatic compare_cycle();
    for (int k = 0; k < 3; k++) begin
      for (int p = 0; p < 2; p++) begin
        int idx;
        int bank;
        int expG;
        int dutG;
        int dutB;
        string tag;
        idx  = int'(idxIn[p*IDX_W +: IDX_W]);
        bank = idx % nbCfg[k];
        expG = 0;
        case (k)
          0: begin dutG = int'(gA[p]); dutB = int'(bA[p*2 +: 2]); end
          1: begin dutG = int'(gB[p]); dutB = int'(bB[p]); end
          default: begin dutG = int'(gC[p]); dutB = int'(bC[p*2 +: 2]); end
        endcase
        if (!vIn[p]) tag = "R9";
        else if (latCfg[k] == 0) begin
          tag = "R3"; expG = 1;
        end else if (mUsed[k][bank] && mEnd[k][bank] >= cyc) begin
          if (mStart[k][bank] == cyc && mIdx[k][bank] == idx) begin
            tag = "R6"; expG = 1;
          end else tag = (mStart[k][bank] == cyc) ? "R5" : "R4";
        end else begin
          tag = mUsed[k][bank] ? "R7" : "R8";
          expG = 1;
          mUsed[k][bank]  = 1'b1;
          mStart[k][bank] = cyc;
          mEnd[k][bank]   = cyc + latCfg[k] - 1;
          mIdx[k][bank]   = idx;
        end
        check({tag, "/R10"}, dutG, expG, $sformatf("inst%0d port%0d grant", k, p));
        check((nbCfg[k] == 1) ? "R2" : "R1", dutB, bank,
              $sformatf("inst%0d port%0d bank", k, p));
      end
    end
    cyc++;
  endtask

  task automatic drive(bit v0, int i0, bit v1, int i1);
    @(negedge clk);
    vIn = {v1, v0};
    idxIn = {IDX_W'(i1), IDX_W'(i0)};
    #5;
    compare_cycle();
  endtask

  initial begin
    logic [15:0] lfsr;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R8/R9: idle after reset, then both ports hit free banks.
    drive(0, 0, 0, 0);
    drive(1, 3, 1, 6);
    drive(0, 0, 0, 0);
    drive(0, 0, 0, 0);
    drive(0, 0, 0, 0);
    // R6: same index on both ports in the claiming cycle.
    drive(1, 5, 1, 5);
    // R4 + R7: bank 1 held, other bank free.
    drive(1, 9, 1, 2);
    drive(1, 1, 0, 0);
    // R4: admitted exactly LATENCY cycles after the claim (denials did not extend it).
    drive(1, 13, 0, 0);
    drive(0, 0, 0, 0);
    drive(0, 0, 0, 0);
    drive(0, 0, 0, 0);
    // R5: different indices, same free bank, same cycle.
    drive(1, 4, 1, 8);
    // R1: high index bits ignored for bank choice.
    drive(1, 8'hF6, 1, 8'h7F);
    lfsr = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      int i0;
      int i1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      i0 = int'(lfsr[3:0]);
      i1 = lfsr[8] ? i0 : int'(lfsr[7:4]);
      drive(lfsr[9] | lfsr[11], i0, lfsr[10], i1);
    end
    drive(0, 0, 0, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule